// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Controller

This block is the control front end that a floating-point coprocessor presents to its integer unit. The integer unit places an instruction word on a shared 32-bit bus and pulses an instruction strobe during its Execute stage. One stage later, during its Write stage, it places that instruction's address on the same bus with an address strobe. The controller holds the instruction/address pairs in a queue of two entries. When the integer unit pulses the end strobe in the last pipeline cycle of the oldest instruction, that pair is handed to the execution pipeline.

The controller applies back-pressure through an active-low hold output. Hold is asserted when the datapath reports a register dependency at Write-stage time, and also after an instruction arrives that the full queue had to turn away. An active-low exception output is sticky until the integer unit acknowledges it. A two-bit condition code is published with a valid flag. The flag is low while any accepted compare has not yet completed, so the integer unit can stall a branch that tests the code.

Top module: `fpc_issue_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `hold_n`=1, `exc_n`=1, `cc_valid`=1, `cc_out`=0 and `issue_valid`=0.
- R2: A word on `f_bus` in a cycle with `ins_stb` high is accepted when the queue holds fewer than 2 entries, or when `end_stb` frees a slot in the same cycle. Entries leave in arrival order.
- R3: A cycle with `adr_stb` high and `ins_stb` low stores `f_bus` as the address of the youngest entry in the queue. If that entry is issued in the same cycle, the issued address is the bus value.
- R4: The queue holds at most 2 entries. An instruction strobe while the queue is full and `end_stb` is low leaves the queue unchanged. `hold_n` then goes low from the next cycle and returns high in the cycle after the next `end_stb`.
- R5: `hold_n` is low in the same cycle when `adr_stb` and `dep_hit` are both high. It stays low in following cycles while `dep_hit` remains high, and goes high in the first cycle `dep_hit` is low. `dep_hit` on its own, with no preceding address strobe, does not lower `hold_n`.
- R6: `exc_n` goes low in the cycle after `exc_det` is seen while the queue is not empty. It stays low until `exc_ack` is high, and it is high in the cycle after that. `exc_ack` wins over a simultaneous `exc_det`.
- R7: `exc_det` while the queue is empty leaves `exc_n` high.
- R8: `flush` empties the queue, so a following `end_stb` issues nothing. It releases `hold_n` in the flush cycle and in the cycle after, and it cancels outstanding compares. It does not clear a pending exception.
- R9: An accepted word with bits[31:30]=2'b10, bits[24:19]=6'b110101 and bits[13:8]=6'b001010 is a compare. `cc_valid` is low from the cycle after such a word is accepted until the cycle after the matching `cmp_done`. Other words leave `cc_valid` unchanged.
- R10: `cc_out` takes the value of `cc_in` in the cycle after `cmp_done` is high, with 00 = equal, 01 = less, 10 = greater, 11 = unordered.
- R11: `end_stb` while the queue is empty leaves `issue_valid` low in the next cycle. Otherwise `issue_valid` is high in the cycle after `end_stb`, together with that entry's word and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_bus | input | 32 | Shared instruction/address bus |
| ins_stb | input | 1 | Instruction word present on bus |
| adr_stb | input | 1 | Instruction address present on bus |
| end_stb | input | 1 | Oldest instruction leaves the integer pipeline |
| flush | input | 1 | Discard queued instructions and pending hold |
| dep_hit | input | 1 | Register dependency reported by the datapath |
| exc_det | input | 1 | Exception detected by the datapath |
| exc_ack | input | 1 | Integer unit has taken the exception trap |
| cmp_done | input | 1 | A compare has finished |
| cc_in | input | 2 | Condition code produced by the finished compare |
| hold_n | output | 1 | Active-low hold to the integer unit |
| exc_n | output | 1 | Active-low sticky exception |
| cc_out | output | 2 | Published condition code |
| cc_valid | output | 1 | `cc_out` is current |
| issue_valid | output | 1 | An entry is handed to execution this cycle |
| issue_insn | output | 32 | Word of the issued entry |
| issue_addr | output | 32 | Address of the issued entry |

## Verification
The bench sweeps every 5-cycle pattern of instruction and end strobes from an empty queue against a queue model. This exposes a design that miscounts when a push and a pop land together at full occupancy, since such a design would drop or duplicate a word. It would also expose an overflow hold that is released in the wrong cycle. Directed cases cover an address strobe aimed at an entry that leaves in the same cycle, which a design without the bypass would issue with a stale address. They also cover an acknowledge that collides with a new detection, where a wrong priority leaves the exception stuck. Flush is tested against a full queue and compares in flight: a design that missed any of these would issue ghost entries or keep `cc_valid` low forever.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CC_W   = 2;

    typedef struct packed {
        logic [WORD_W-1:0] insn;
        logic [WORD_W-1:0] addr;
    } fpc_entry_t;

    typedef enum logic [CC_W-1:0] {
        FCC_EQ = 2'b00,
        FCC_LT = 2'b01,
        FCC_GT = 2'b10,
        FCC_UN = 2'b11
    } fcc_e;

    // Compare class: op=10, op3=110101, opf[8:3]=001010
    function automatic logic is_fcmp(input logic [WORD_W-1:0] w);
        return (w[31:30] == 2'b10) && (w[24:19] == 6'b110101) &&
               (w[13:8] == 6'b001010);
    endfunction

endpackage

// File: rtl/fpc_insn_queue.sv
module fpc_insn_queue
    import fpc_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [WORD_W-1:0] bus,
    input  logic              ins_stb,
    input  logic              adr_stb,
    input  logic              end_stb,
    output logic              push,
    output logic              pop,
    output logic              reject,
    output logic              busy,
    output logic              issue_valid,
    output logic [WORD_W-1:0] issue_insn,
    output logic [WORD_W-1:0] issue_addr
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    fpc_entry_t       slot_q [DEPTH];
    fpc_entry_t       slot_d [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] wr_idx;
    logic [CNT_W-1:0] adr_idx;
    logic             full;
    logic             adr_we;
    logic             adr_live;
    logic             adr_bypass;

    assign busy     = (cnt_q != '0);
    assign full     = (cnt_q == FULL_CNT);
    assign pop      = end_stb && busy;
    assign push     = ins_stb && (!full || pop);
    assign reject   = ins_stb && full && !pop;
    assign adr_we   = adr_stb && !ins_stb && busy;
    // youngest entry index after this cycle's shift
    assign wr_idx   = cnt_q - CNT_W'(pop);
    assign adr_idx  = cnt_q - CNT_W'(1) - CNT_W'(pop);
    assign adr_live = !(pop && (cnt_q == CNT_W'(1)));
    assign adr_bypass = adr_we && !adr_live;

    assign cnt_d = flush ? '0 : (cnt_q + CNT_W'(push) - CNT_W'(pop));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        fpc_entry_t shifted;
        fpc_entry_t base;
        logic       take_insn;
        logic       take_addr;
        if (g < DEPTH - 1) begin : g_mid
            assign shifted = slot_q[g+1];
        end else begin : g_last
            assign shifted = '0;
        end
        assign base      = pop ? shifted : slot_q[g];
        assign take_insn = push && (wr_idx == CNT_W'(g));
        assign take_addr = adr_we && adr_live && (adr_idx == CNT_W'(g));
        assign slot_d[g] = '{
            insn: take_insn ? bus : base.insn,
            addr: take_insn ? '0 : (take_addr ? bus : base.addr)
        };
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            issue_valid <= 1'b0;
            issue_insn  <= '0;
            issue_addr  <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            cnt_q       <= cnt_d;
            issue_valid <= pop && !flush;
            if (pop && !flush) begin
                issue_insn <= slot_q[0].insn;
                issue_addr <= adr_bypass ? bus : slot_q[0].addr;
            end
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

endmodule

// File: rtl/fpc_hold_ctrl.sv
module fpc_hold_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic adr_stb,
    input  logic dep_hit,
    input  logic reject,
    input  logic pop,
    output logic hold_n
);
    logic dep_pend_q;
    logic ovf_q;
    logic dep_now;

    assign dep_now = dep_hit && (adr_stb || dep_pend_q);
    assign hold_n  = !(!flush && (dep_now || ovf_q));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            dep_pend_q <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            dep_pend_q <= dep_now;
            if (pop)
                ovf_q <= 1'b0;
            else if (reject)
                ovf_q <= 1'b1;
        end
    end

endmodule

// File: rtl/fpc_exc_latch.sv
module fpc_exc_latch (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic exc_det,
    input  logic exc_ack,
    output logic exc_n
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (exc_ack)
            pend_q <= 1'b0;
        else if (exc_det && busy)
            pend_q <= 1'b1;
    end

    assign exc_n = !pend_q;

endmodule

// File: rtl/fpc_cc_track.sv
module fpc_cc_track
    import fpc_pkg::*;
#(
    parameter int unsigned MAX_CMP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] bus,
    input  logic              cmp_done,
    input  logic [CC_W-1:0]   cc_in,
    output logic [CC_W-1:0]   cc_out,
    output logic              cc_valid
);
    localparam int unsigned CW = $clog2(MAX_CMP + 1);
    localparam logic [CW-1:0] CMAX = CW'(MAX_CMP);

    logic [CW-1:0] open_q;
    logic          cmp_in;
    logic          cmp_out;

    assign cmp_in  = push && is_fcmp(bus) && (open_q != CMAX);
    assign cmp_out = cmp_done && (open_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= '0;
            cc_out <= FCC_EQ;
        end else begin
            open_q <= flush ? '0 : (open_q + CW'(cmp_in) - CW'(cmp_out));
            if (cmp_done) cc_out <= cc_in;
        end
    end

    assign cc_valid = (open_q == '0);

endmodule

// File: rtl/fpc_issue_ctrl.sv
module fpc_issue_ctrl
    import fpc_pkg::*;
#(
    parameter int unsigned DEPTH   = 2,
    parameter int unsigned MAX_CMP = DEPTH + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] f_bus,
    input  logic              ins_stb,
    input  logic              adr_stb,
    input  logic              end_stb,
    input  logic              flush,
    input  logic              dep_hit,
    input  logic              exc_det,
    input  logic              exc_ack,
    input  logic              cmp_done,
    input  logic [CC_W-1:0]   cc_in,
    output logic              hold_n,
    output logic              exc_n,
    output logic [CC_W-1:0]   cc_out,
    output logic              cc_valid,
    output logic              issue_valid,
    output logic [WORD_W-1:0] issue_insn,
    output logic [WORD_W-1:0] issue_addr
);
    logic push;
    logic pop;
    logic reject;
    logic busy;

    fpc_insn_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .flush(flush), .bus(f_bus),
        .ins_stb(ins_stb), .adr_stb(adr_stb), .end_stb(end_stb),
        .push(push), .pop(pop), .reject(reject), .busy(busy),
        .issue_valid(issue_valid), .issue_insn(issue_insn),
        .issue_addr(issue_addr)
    );

    fpc_hold_ctrl u_hold (
        .clk(clk), .rst(rst), .flush(flush), .adr_stb(adr_stb),
        .dep_hit(dep_hit), .reject(reject), .pop(pop), .hold_n(hold_n)
    );

    fpc_exc_latch u_exc (
        .clk(clk), .rst(rst), .busy(busy), .exc_det(exc_det),
        .exc_ack(exc_ack), .exc_n(exc_n)
    );

    fpc_cc_track #(.MAX_CMP(MAX_CMP)) u_cc (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .bus(f_bus),
        .cmp_done(cmp_done), .cc_in(cc_in), .cc_out(cc_out),
        .cc_valid(cc_valid)
    );

endmodule

// File: rtl/fpc_issue_ctrl_chk.sv
module fpc_issue_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       adr_stb,
    input logic       dep_hit,
    input logic       exc_det,
    input logic       exc_ack,
    input logic       end_stb,
    input logic       cmp_done,
    input logic [1:0] cc_in,
    input logic       hold_n,
    input logic       exc_n,
    input logic [1:0] cc_out,
    input logic       issue_valid
);
    // R5
    dep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        adr_stb && dep_hit && !flush |-> !hold_n);

    // R8
    flush_release_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> hold_n);

    // R6
    exc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_n && !exc_ack |=> !exc_n);

    // R6
    exc_release_chk: assert property (@(posedge clk) disable iff (rst)
        exc_ack |=> exc_n);

    // R7
    exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        exc_n && !exc_det |=> exc_n);

    // R10
    cc_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_done |=> cc_out == $past(cc_in));

    // R11
    issue_cause_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> $past(end_stb) && !$past(flush));

endmodule

bind fpc_issue_ctrl fpc_issue_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .flush(flush), .adr_stb(adr_stb),
    .dep_hit(dep_hit), .exc_det(exc_det), .exc_ack(exc_ack),
    .end_stb(end_stb), .cmp_done(cmp_done), .cc_in(cc_in),
    .hold_n(hold_n), .exc_n(exc_n), .cc_out(cc_out),
    .issue_valid(issue_valid)
);

// File: tb/fpc_issue_ctrl_tb.sv
`timescale 1ns/100ps
module fpc_issue_ctrl_tb_top;
    import fpc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] f_bus = '0;
    logic        ins_stb = 0, adr_stb = 0, end_stb = 0, flush = 0;
    logic        dep_hit = 0, exc_det = 0, exc_ack = 0, cmp_done = 0;
    logic [1:0]  cc_in = '0;
    logic        hold_n, exc_n, cc_valid, issue_valid;
    logic [1:0]  cc_out;
    logic [31:0] issue_insn, issue_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fpc_issue_ctrl dut_i (
        .clk(clk), .rst(rst), .f_bus(f_bus), .ins_stb(ins_stb),
        .adr_stb(adr_stb), .end_stb(end_stb), .flush(flush),
        .dep_hit(dep_hit), .exc_det(exc_det), .exc_ack(exc_ack),
        .cmp_done(cmp_done), .cc_in(cc_in), .hold_n(hold_n),
        .exc_n(exc_n), .cc_out(cc_out), .cc_valid(cc_valid),
        .issue_valid(issue_valid), .issue_insn(issue_insn),
        .issue_addr(issue_addr)
    );

    localparam logic [31:0] CMP_W  = 32'h81A8_0A02;
    localparam logic [31:0] MUL_W  = 32'h81A0_0A00;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ins_stb = 0; adr_stb = 0; end_stb = 0; flush = 0;
        exc_det = 0; exc_ack = 0; cmp_done = 0; dep_hit = 0;
    endtask

    // drive for one cycle, then clear strobes
    task automatic cyc(input bit ins, input bit adr, input bit en,
                       input bit fl, input logic [31:0] b);
        ins_stb = ins; adr_stb = adr; end_stb = en; flush = fl; f_bus = b;
        tick();
        idle();
    endtask

    initial begin
        #950000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] mq[$];
        bit          ovf;
        logic [31:0] next_w;
        // R1 reset state
        repeat (3) tick();
        check("R1 hold_n", 32'(hold_n), 1);
        check("R1 exc_n", 32'(exc_n), 1);
        check("R1 cc_valid", 32'(cc_valid), 1);
        check("R1 cc_out", 32'(cc_out), 0);
        rst = 0;
        tick();
        check("R1 issue_valid", 32'(issue_valid), 0);
        check("R1 hold_n after", 32'(hold_n), 1);

        // R2/R3 order and address pairing
        cyc(1, 0, 0, 0, 32'h0000_00A1);
        cyc(0, 1, 0, 0, 32'h0000_A1A1);
        cyc(1, 0, 0, 0, 32'h0000_00B2);
        cyc(0, 1, 0, 0, 32'h0000_B2B2);
        cyc(0, 0, 1, 0, '0);
        check("R2 issue_valid", 32'(issue_valid), 1);
        check("R2 first word", issue_insn, 32'h0000_00A1);
        check("R3 first addr", issue_addr, 32'h0000_A1A1);
        cyc(0, 0, 1, 0, '0);
        check("R2 second word", issue_insn, 32'h0000_00B2);
        check("R3 second addr", issue_addr, 32'h0000_B2B2);
        tick();
        check("R11 issue drops", 32'(issue_valid), 0);

        // R3 bypass: address and end strobe for a single entry together
        cyc(1, 0, 0, 0, 32'h0000_00C3);
        cyc(0, 1, 1, 0, 32'h0000_C3C3);
        check("R3 bypass word", issue_insn, 32'h0000_00C3);
        check("R3 bypass addr", issue_addr, 32'h0000_C3C3);

        // R4 overflow
        cyc(1, 0, 0, 0, 32'h0000_0011);
        cyc(1, 0, 0, 0, 32'h0000_0022);
        check("R4 no hold at two", 32'(hold_n), 1);
        cyc(1, 0, 0, 0, 32'h0000_0033);
        check("R4 hold after reject", 32'(hold_n), 0);
        tick();
        check("R4 hold persists", 32'(hold_n), 0);
        cyc(0, 0, 1, 0, '0);
        check("R4 hold released", 32'(hold_n), 1);
        check("R4 oldest issued", issue_insn, 32'h0000_0011);
        cyc(1, 0, 1, 0, 32'h0000_0044);
        check("R4 push+pop word", issue_insn, 32'h0000_0022);
        check("R4 push+pop hold", 32'(hold_n), 1);
        cyc(0, 0, 1, 0, '0);
        check("R4 rejected word dropped", issue_insn, 32'h0000_0044);
        cyc(0, 0, 1, 0, '0);
        check("R11 empty end", 32'(issue_valid), 0);

        // R5 dependency hold (combinational)
        cyc(1, 0, 0, 0, 32'h0000_0055);
        dep_hit = 1; #0.5;
        check("R5 dep alone", 32'(hold_n), 1);
        adr_stb = 1; f_bus = 32'h0000_5555; #0.5;
        check("R5 hold on write stage", 32'(hold_n), 0);
        tick();
        adr_stb = 0; dep_hit = 1; #0.5;
        check("R5 hold persists", 32'(hold_n), 0);
        tick();
        dep_hit = 1; #0.5;
        check("R5 hold still", 32'(hold_n), 0);
        dep_hit = 0; #0.5;
        check("R5 hold clears", 32'(hold_n), 1);
        tick();
        check("R5 stays clear", 32'(hold_n), 1);

        // R6 exception handshake (queue holds 0x55)
        exc_det = 1; tick(); idle();
        check("R6 exc asserted", 32'(exc_n), 0);
        repeat (3) tick();
        check("R6 exc sticky", 32'(exc_n), 0);
        exc_ack = 1; exc_det = 1; tick(); idle();
        check("R6 ack wins", 32'(exc_n), 1);
        exc_det = 1; tick(); idle();
        check("R6 exc again", 32'(exc_n), 0);
        // R8 flush with pending exception, full queue and overflow
        cyc(1, 0, 0, 0, 32'h0000_0066);
        cyc(1, 0, 0, 0, 32'h0000_0077);
        check("R8 hold before flush", 32'(hold_n), 0);
        flush = 1; #0.5;
        check("R8 hold released in flush", 32'(hold_n), 1);
        tick(); idle();
        check("R8 hold after flush", 32'(hold_n), 1);
        check("R8 exception kept", 32'(exc_n), 0);
        cyc(0, 0, 1, 0, '0);
        check("R8 queue empty", 32'(issue_valid), 0);
        exc_ack = 1; tick(); idle();
        // R7 exception ignored while empty
        exc_det = 1; tick(); idle();
        check("R7 empty ignore", 32'(exc_n), 1);

        // R9/R10 condition codes
        cyc(1, 0, 0, 0, MUL_W);
        check("R9 non-compare", 32'(cc_valid), 1);
        cyc(0, 0, 1, 0, '0);
        cyc(1, 0, 0, 0, CMP_W);
        check("R9 compare drops valid", 32'(cc_valid), 0);
        cyc(1, 0, 0, 0, CMP_W ^ 32'h0000_0060);
        cmp_done = 1; cc_in = FCC_GT; tick(); idle();
        check("R9 one of two done", 32'(cc_valid), 0);
        check("R10 cc greater", 32'(cc_out), 32'(FCC_GT));
        cmp_done = 1; cc_in = FCC_UN; tick(); idle();
        check("R9 valid again", 32'(cc_valid), 1);
        check("R10 cc unordered", 32'(cc_out), 32'(FCC_UN));
        cyc(1, 0, 0, 1, CMP_W);
        check("R9 compare under flush", 32'(cc_valid), 1);
        cyc(1, 0, 0, 0, CMP_W);
        cyc(0, 0, 0, 1, '0);
        check("R8 flush cancels compare", 32'(cc_valid), 1);
        cmp_done = 1; cc_in = FCC_LT; tick(); idle();
        check("R10 cc less", 32'(cc_out), 32'(FCC_LT));
        check("R9 stray done", 32'(cc_valid), 1);

        // R2/R4/R11 sweep: every 5-cycle pattern of (ins,end)
        next_w = 32'h0010_0000;
        for (int p = 0; p < 1024; p++) begin
            cyc(0, 0, 0, 1, '0);
            mq.delete();
            ovf = 0;
            for (int c = 0; c < 5; c++) begin
                bit ins;
                bit en;
                bit popm;
                bit fullm;
                logic [31:0] expw;
                ins = p[2*c];
                en  = p[2*c+1];
                fullm = (mq.size() == 2);
                popm  = en && (mq.size() != 0);
                expw  = popm ? mq[0] : '0;
                cyc(ins, 0, en, 0, next_w);
                if (popm) void'(mq.pop_front());
                if (ins && (!fullm || popm)) mq.push_back(next_w);
                if (popm) ovf = 0;
                else if (ins && fullm) ovf = 1;
                next_w++;
                check("R11 sweep valid", 32'(issue_valid), 32'(popm));
                if (popm) check("R2 sweep word", issue_insn, expw);
                check("R4 sweep hold", 32'(hold_n), 32'(!ovf));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule